// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block resolves the result of a two-operand binary32 operation in which at least one operand is a NaN. It accepts operands A and B together with a policy code and a default-result mode bit. From these it decides which operand's NaN is forwarded, quiets that NaN, and records an invalid-operation event in a sticky status bit whenever either operand is a signalling NaN. When default-result mode is on, the output is forced to a fixed canonical quiet NaN. The invalid event is still recorded in that mode.

A NaN has all exponent bits set and a non-zero fraction. Fraction bit 22 (the most significant fraction bit) set marks a quiet NaN. That bit clear, with any lower fraction bit set, marks a signalling NaN. Quieting sets bit 22 of a signalling NaN and keeps every other bit.

The control is a two-state machine. In S_IDLE, a request with `in_valid` high is captured and the transition CAPTURE moves to S_RESOLVE. In S_RESOLVE, the result is computed and registered, and the transition RETIRE returns to S_IDLE unconditionally. Requests that arrive while in S_RESOLVE are dropped.

Top module: `nan_prop_sel`

## Requirements
- R1: An operand is quiet when bits 30:23 are all one and bit 22 is one. It is signalling when bits 30:23 are all one, bit 22 is zero and bits 21:0 are non-zero. Anything else, including infinity 0x7F800000, is not a NaN.
- R2: The forwarded operand is quieted: a signalling NaN has bit 22 set and all other bits kept, and a quiet NaN passes unchanged.
- R3: Policy code 0 forwards the first of the following that applies: A if A is signalling, then B if B is signalling, then A if A is quiet, and otherwise B.
- R4: Policy code 1 forwards A if A is any NaN, and otherwise forwards B.
- R5: Under policy code 2, a signalling NaN paired with a quiet NaN forwards the quiet one. A NaN paired with a non-NaN forwards the NaN.
- R6: Under policy code 2, when both operands are signalling or both are quiet, the one with the larger value of bits 30:0 is forwarded. When those magnitudes are equal, A is forwarded only if A is lower as a raw 32-bit word, so the positive-signed operand is forwarded.
- R7: Policy code 3 behaves exactly as policy code 0.
- R8: With `dflt_mode` high, the result is 0x7FC00000 whatever the operands and the policy.
- R9: `invalid_flag` is set when either operand is signalling, including in default-result mode. An operation with only quiet NaNs leaves it unchanged.
- R10: `invalid_flag` is cleared only by `flag_clr`. If a clear and a new invalid event fall in the same cycle, the flag ends up set.
- R11: A request is accepted only in S_IDLE. `res_valid` is a one-cycle pulse on the second rising edge after acceptance. A request presented while in S_RESOLVE is ignored, and `res` holds its value between results.
- R12: After reset, `res_valid`, `res` and `invalid_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe; sampled in S_IDLE only |
| op_a | input | 32 | Operand A, binary32 |
| op_b | input | 32 | Operand B, binary32 |
| policy | input | 2 | Selection rule code (0, 1, 2; 3 behaves as 0) |
| dflt_mode | input | 1 | Force the canonical default NaN result |
| flag_clr | input | 1 | Clear the sticky invalid flag |
| res_valid | output | 1 | One-cycle result strobe |
| res | output | 32 | Selected, quieted NaN (or default NaN) |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
Two functions can act on the sticky flag in the same cycle: the clear request and a new invalid event raised at the end of S_RESOLVE. The bench provokes this by starting a request with a signalling operand and holding `flag_clr` high exactly in the resolve cycle. It then expects the flag to read one, and afterwards a lone clear to bring it back to zero. The selection rules are judged independently through the forwarded result word, using operand pairs whose forwarded NaN differs by sign and payload.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

    typedef enum logic [1:0] {
        POL_ORDERED   = 2'd0,
        POL_FIRST_NAN = 2'd1,
        POL_MAGNITUDE = 2'd2,
        POL_RSVD      = 2'd3
    } nan_policy_e;

    typedef enum logic {
        S_IDLE    = 1'b0,
        S_RESOLVE = 1'b1
    } sel_state_e;

    typedef struct packed {
        logic is_nan;
        logic quiet;
        logic sig;
    } nan_class_t;

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
    import nanp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] val,
    output nan_class_t            cls
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic exp_ones;
    logic top_frac;
    logic low_frac;

    always_comb begin
        exp_ones   = &val[W-2 -: EXP_W];
        top_frac   = val[FRAC_W-1];
        low_frac   = |val[FRAC_W-2:0];
        cls.quiet  = exp_ones && top_frac;
        cls.sig    = exp_ones && !top_frac && low_frac;
        cls.is_nan = cls.quiet || cls.sig;
    end
endmodule

// File: rtl/nanp_pick.sv
module nanp_pick
    import nanp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  nan_class_t       ca,
    input  nan_class_t       cb,
    input  nan_policy_e      policy,
    output logic             pick_b
);
    logic a_larger;

    always_comb begin
        if (a[WIDTH-2:0] != b[WIDTH-2:0])
            a_larger = a[WIDTH-2:0] > b[WIDTH-2:0];
        else
            a_larger = a < b;
    end

    always_comb begin
        unique case (policy)
            POL_FIRST_NAN: pick_b = !ca.is_nan;
            POL_MAGNITUDE: begin
                if (ca.sig)
                    pick_b = cb.sig ? !a_larger : cb.quiet;
                else if (ca.quiet)
                    pick_b = cb.quiet ? !a_larger : 1'b0;
                else
                    pick_b = 1'b1;
            end
            POL_ORDERED, POL_RSVD: begin
                if (ca.sig)
                    pick_b = 1'b0;
                else if (cb.sig)
                    pick_b = 1'b1;
                else if (ca.quiet)
                    pick_b = 1'b0;
                else
                    pick_b = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/nanp_quiet.sv
module nanp_quiet
    import nanp_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int QBIT   = 22
) (
    input  logic [WIDTH-1:0] val,
    input  nan_class_t       cls,
    output logic [WIDTH-1:0] qval
);
    always_comb begin
        qval = val;
        if (cls.sig)
            qval[QBIT] = 1'b1;
    end
endmodule

// File: rtl/nan_prop_sel.sv
module nan_prop_sel
    import nanp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [EXP_W+FRAC_W:0]    op_a,
    input  logic [EXP_W+FRAC_W:0]    op_b,
    input  logic [1:0]               policy,
    input  logic                     dflt_mode,
    input  logic                     flag_clr,
    output logic                     res_valid,
    output logic [EXP_W+FRAC_W:0]    res,
    output logic                     invalid_flag
);
    localparam int WIDTH = EXP_W + FRAC_W + 1;
    localparam int QBIT  = FRAC_W - 1;
    localparam logic [WIDTH-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    sel_state_e  state_q, state_d;
    logic [WIDTH-1:0] opnd_q [2];
    nan_class_t  cls [2];
    nan_policy_e pol_q;
    logic        dm_q;
    logic        pick_b;
    logic [WIDTH-1:0] chosen;
    nan_class_t  chosen_cls;
    logic [WIDTH-1:0] chosen_q;
    logic        raise;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        nanp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
            .val (opnd_q[i]),
            .cls (cls[i])
        );
    end

    nanp_pick #(.WIDTH(WIDTH)) pick_i (
        .a      (opnd_q[0]),
        .b      (opnd_q[1]),
        .ca     (cls[0]),
        .cb     (cls[1]),
        .policy (pol_q),
        .pick_b (pick_b)
    );

    always_comb begin
        chosen     = pick_b ? opnd_q[1] : opnd_q[0];
        chosen_cls = pick_b ? cls[1] : cls[0];
    end

    nanp_quiet #(.WIDTH(WIDTH), .QBIT(QBIT)) quiet_i (
        .val  (chosen),
        .cls  (chosen_cls),
        .qval (chosen_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // transitions: CAPTURE (S_IDLE -> S_RESOLVE), RETIRE (S_RESOLVE -> S_IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (in_valid) state_d = S_RESOLVE;
            S_RESOLVE: state_d = S_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opnd_q[0] <= '0;
            opnd_q[1] <= '0;
            pol_q     <= POL_ORDERED;
            dm_q      <= 1'b0;
        end else if (state_q == S_IDLE && in_valid) begin
            opnd_q[0] <= op_a;
            opnd_q[1] <= op_b;
            pol_q     <= nan_policy_e'(policy);
            dm_q      <= dflt_mode;
        end
    end

    assign raise = (state_q == S_RESOLVE) && (cls[0].sig || cls[1].sig);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res          <= '0;
            invalid_flag <= 1'b0;
        end else begin
            res_valid    <= 1'b0;
            invalid_flag <= (invalid_flag && !flag_clr) || raise;
            unique case (state_q)
                S_IDLE: ;
                S_RESOLVE: begin
                    res_valid <= 1'b1;
                    res       <= dm_q ? DEFAULT_NAN : chosen_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/nan_prop_sel_chk.sv
module nan_prop_sel_chk
    import nanp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             flag_clr,
    input logic             busy,
    input logic             dm_q,
    input logic             any_sig,
    input logic             any_nan,
    input logic             res_valid,
    input logic [WIDTH-1:0] res,
    input logic             invalid_flag
);
    localparam int FRAC_W = 23;

    // R11
    res_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid) |=> ##1 res_valid);

    // R11
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R2
    res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && any_nan) |=> (&res[WIDTH-2:FRAC_W-1]));

    // R8
    dflt_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dm_q) |=> (res == 32'h7FC0_0000));

    // R9
    invalid_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && any_sig) |=> invalid_flag);

    // R10
    invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_flag && !flag_clr) |=> invalid_flag);
endmodule

bind nan_prop_sel nan_prop_sel_chk #(.WIDTH(WIDTH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .flag_clr     (flag_clr),
    .busy         (state_q == nanp_pkg::S_RESOLVE),
    .dm_q         (dm_q),
    .any_sig      (cls[0].sig || cls[1].sig),
    .any_nan      (cls[0].is_nan || cls[1].is_nan),
    .res_valid    (res_valid),
    .res          (res),
    .invalid_flag (invalid_flag)
);

// File: tb/nan_prop_sel_tb_top.sv
`timescale 1ns/1ps
module nan_prop_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  policy = '0;
    logic        dflt_mode = 1'b0;
    logic        flag_clr = 1'b0;
    logic        res_valid;
    logic [31:0] res;
    logic        invalid_flag;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] AS  = 32'h7F80_0005;
    localparam logic [31:0] ASQ = 32'h7FC0_0005;
    localparam logic [31:0] BS  = 32'hFF80_0003;
    localparam logic [31:0] BSQ = 32'hFFC0_0003;
    localparam logic [31:0] AQ  = 32'h7FC0_0010;
    localparam logic [31:0] BQ  = 32'hFFC0_0020;
    localparam logic [31:0] ONE = 32'h3F80_0000;
    localparam logic [31:0] INF = 32'h7F80_0000;
    localparam logic [31:0] DNAN = 32'h7FC0_0000;

    always #2.5 clk = ~clk;

    nan_prop_sel dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .policy(policy), .dflt_mode(dflt_mode), .flag_clr(flag_clr),
        .res_valid(res_valid), .res(res), .invalid_flag(invalid_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // drive one request and sample after the result edge
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] pol, input logic dm,
                          input logic [31:0] exp_res, input logic exp_inv);
        clear_flag();
        @(negedge clk);
        op_a = a; op_b = b; policy = pol; dflt_mode = dm; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check({req, " valid"}, {31'd0, res_valid}, 32'd1);
        check({req, " result"}, res, exp_res);
        check({req, " invalid"}, {31'd0, invalid_flag}, {31'd0, exp_inv});
    endtask

    task automatic t_reset();
        check("R12 res_valid", {31'd0, res_valid}, 32'd0);
        check("R12 res", res, 32'd0);
        check("R12 invalid", {31'd0, invalid_flag}, 32'd0);
    endtask

    task automatic t_classify();
        run_op("R1 infinity not NaN", INF, BQ, 2'd1, 1'b0, BQ, 1'b0);
        run_op("R1 quiet zero payload", ONE, DNAN, 2'd0, 1'b0, DNAN, 1'b0);
        run_op("R2 signalling quieted", AS, ONE, 2'd1, 1'b0, ASQ, 1'b1);
    endtask

    task automatic t_policy0();
        run_op("R3 B signalling over A quiet", AQ, BS, 2'd0, 1'b0, BSQ, 1'b1);
        run_op("R3 both signalling", AS, BS, 2'd0, 1'b0, ASQ, 1'b1);
        run_op("R3 both quiet", AQ, BQ, 2'd0, 1'b0, AQ, 1'b0);
        run_op("R3 number and quiet", ONE, BQ, 2'd0, 1'b0, BQ, 1'b0);
        run_op("R7 code 3 as code 0", AQ, BS, 2'd3, 1'b0, BSQ, 1'b1);
    endtask

    task automatic t_policy1();
        run_op("R4 A quiet over B signalling", AQ, BS, 2'd1, 1'b0, AQ, 1'b1);
        run_op("R4 number A", ONE, BS, 2'd1, 1'b0, BSQ, 1'b1);
    endtask

    task automatic t_policy2();
        run_op("R5 signalling vs quiet", AS, BQ, 2'd2, 1'b0, BQ, 1'b1);
        run_op("R5 quiet vs signalling", AQ, BS, 2'd2, 1'b0, AQ, 1'b1);
        run_op("R5 NaN vs number", AS, ONE, 2'd2, 1'b0, ASQ, 1'b1);
        run_op("R6 quiet larger B", AQ, BQ, 2'd2, 1'b0, BQ, 1'b0);
        run_op("R6 signalling larger A", AS, BS, 2'd2, 1'b0, ASQ, 1'b1);
        run_op("R6 tie B positive", 32'hFFC0_0010, 32'h7FC0_0010, 2'd2, 1'b0, 32'h7FC0_0010, 1'b0);
        run_op("R6 tie A positive", 32'h7FC0_0011, 32'hFFC0_0011, 2'd2, 1'b0, 32'h7FC0_0011, 1'b0);
        run_op("R6 tie signalling", 32'hFF80_0007, 32'h7F80_0007, 2'd2, 1'b0, 32'h7FC0_0007, 1'b1);
    endtask

    task automatic t_default();
        run_op("R8 default with signalling", AS, BQ, 2'd0, 1'b1, DNAN, 1'b1);
        run_op("R9 default quiet only", AQ, BQ, 2'd2, 1'b1, DNAN, 1'b0);
    endtask

    task automatic t_sticky();
        // R10 clear and raise in the same cycle: set wins
        clear_flag();
        @(negedge clk);
        op_a = AS; op_b = BQ; policy = 2'd0; dflt_mode = 1'b0; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0; flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R10 set wins over clear", {31'd0, invalid_flag}, 32'd1);
        // R9 a later quiet-only op keeps the flag
        @(negedge clk);
        op_a = AQ; op_b = BQ; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check("R9 flag held by quiet op", {31'd0, invalid_flag}, 32'd1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R10 lone clear", {31'd0, invalid_flag}, 32'd0);
    endtask

    task automatic t_busy();
        clear_flag();
        @(negedge clk);
        op_a = AQ; op_b = BQ; policy = 2'd0; dflt_mode = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        op_a = AS; op_b = BS; policy = 2'd1; dflt_mode = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check("R11 first result valid", {31'd0, res_valid}, 32'd1);
        check("R11 first result", res, AQ);
        @(negedge clk);
        check("R11 busy request dropped", {31'd0, res_valid}, 32'd0);
        check("R11 res held", res, AQ);
        check("R11 no invalid from dropped", {31'd0, invalid_flag}, 32'd0);
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_classify();
        t_policy0();
        t_policy1();
        t_policy2();
        t_default();
        t_sticky();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule